// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Controller

This block gathers every interrupt request that can reach a CPU: one nonmaskable line, a bank of external IRQ pins, and a set of request lines from on-chip modules. Each external pin passes through its own programmable sense logic (low level, falling edge, rising edge or either edge), and a detected event is held in a sticky status flag. Software can only clear a flag by writing 0 to its bit. Internal request lines are level inputs held by their modules until serviced.

Each cycle the controller offers at most one winner to the CPU, with its vector number. Two acceptance schemes are selectable. In mask mode, one mask bit from the CPU blocks every maskable source, and the lowest vector number wins. In level mode, each source carries a 3-bit priority taken from a programmable field, and several internal sources share one field. A source is accepted only if its level is strictly above the CPU's 3-bit mask level. The highest level wins, and equal levels go to the lowest vector. The nonmaskable request takes precedence over everything, except while reset is asserted.

The CPU uses the acknowledge input only to retire a pending nonmaskable request. Maskable sources are retired by their owners: a flag write for IRQ pins, and the module's own line for internal sources.

Top module: `ipc_top`

## Requirements
- R1: After reset every register reads 0: sense fields (all IRQs low-level sensed), flags, priority fields and mode. Nothing is pending.
- R2: Register address 0 holds a 2-bit sense field per IRQ k at bits [2k+1:2k]. The encodings are 00 = pin low (the flag is set on every clock edge at which the pin is low), 01 = high-to-low transition, 10 = low-to-high transition, 11 = any transition. The pin history resets to high. The flag is readable one clock edge after the edge that sees the event.
- R3: Address 1 reads the IRQ flags at bit k. A write to address 1 clears each flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. A sense event in the same cycle keeps the flag set.
- R4: Addresses 2, 3 and 4 each hold four 3-bit priority fields. Field j of a register sits at bits [4j+2:4j], and its field index is 4*(address-2)+j. IRQ k uses field k. Internal source m uses field 8+m/2. Bits 3, 7, 11 and 15 read 0.
- R5: Address 5 bit 0 selects the mode: 0 = mask mode, 1 = level mode. Other bits read 0. Addresses 6 and 7 read 0, and writes to them change nothing.
- R6: In mask mode, a high CPU mask bit blocks every maskable source. With the mask bit low, the pending maskable source with the lowest vector is presented, and priority fields are ignored.
- R7: In level mode, a source is accepted only when its level is strictly greater than the CPU mask level, and the CPU mask bit is ignored. A level-7 source is accepted at mask levels 0 to 6, and nothing maskable is accepted at mask level 7.
- R8: In level mode, the accepted source with the highest level wins. A tie goes to the lowest vector.
- R9: IRQ k presents vector 16+k, internal source m presents vector 24+m, and the nonmaskable request presents vector 7.
- R10: A low-to-high transition of the nonmaskable pin (pin history resets to high) makes it pending on the next edge. While pending, it is presented ahead of all sources regardless of mode and masks. An acknowledge clears it, and a pin held high does not re-arm it.
- R11: Request valid and vector follow the current state and inputs in the same cycle. The vector reads 0 when nothing is valid. An acknowledge while a maskable source is presented changes no flag.
- R12: While reset is asserted, no request is presented, even if internal lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (read and write) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| nmi_pin | input | 1 | Nonmaskable request pin, rising-edge armed |
| irq_pin | input | 8 | External IRQ pins |
| int_req | input | 8 | Internal module request lines, active high |
| cpu_imask | input | 1 | CPU global mask bit (mask mode) |
| cpu_level | input | 3 | CPU mask level (level mode) |
| int_valid | output | 1 | A request is presented |
| int_vector | output | 8 | Vector of the presented request |
| int_ack | input | 1 | CPU acknowledge of the presented request |

## Verification
The selection logic is driven with single sources walked across all vectors, with competing sources at distinct levels, and with equal-level ties between an IRQ pin and two internal lines that share one field. Sweeping the CPU mask level from 0 to 7 over each set shows the strict greater-than boundary and separates it from a greater-or-equal comparison. Each sense encoding gets pulses and held levels: a held-low pin keeps re-arming its flag, while edge modes fire once. Flag writes mix 0 and 1 bits, so a clear that disturbs a neighbour or ignores the data becomes visible. A nonmaskable pulse is raised under full masking and then acknowledged with the pin still high, and a maskable acknowledge is shown to leave the flags untouched.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

   // sense selection per external pin
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_FALL = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;

   // width of one priority slot inside a register word
   localparam int SLOT_W     = 4;

   // fixed register addresses; the mode register follows the priority bank
   localparam int ADDR_SENSE = 0;
   localparam int ADDR_FLAG  = 1;
   localparam int ADDR_PRIO0 = 2;

endpackage

// File: rtl/ipc_sense.sv
module ipc_sense
   import ipc_pkg::*;
#(
   parameter int N_IRQ = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_IRQ-1:0]   pin,
   input  logic [2*N_IRQ-1:0] sense,
   input  logic               clr_we,
   input  logic [N_IRQ-1:0]   clr_keep,
   output logic [N_IRQ-1:0]   flag
);

   for (genvar k = 0; k < N_IRQ; k++) begin : g_pin
      logic   prev_q;
      logic   flag_q;
      logic   hit;
      logic   wipe;
      sense_e sel;

      assign sel  = sense_e'(sense[2*k +: 2]);
      assign wipe = clr_we & ~clr_keep[k];

      always_comb begin
         case (sel)
            SENSE_LOW:  hit = ~pin[k];
            SENSE_FALL: hit = prev_q & ~pin[k];
            SENSE_RISE: hit = ~prev_q & pin[k];
            default:    hit = prev_q ^ pin[k];
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b1;
            flag_q <= 1'b0;
         end else begin
            prev_q <= pin[k];
            flag_q <= hit | (flag_q & ~wipe);
         end
      end

      assign flag[k] = flag_q;
   end

endmodule

// File: rtl/ipc_regs.sv
module ipc_regs
   import ipc_pkg::*;
#(
   parameter int N_IRQ   = 8,
   parameter int N_FIELD = 12,
   parameter int LVL_W   = 3,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [N_IRQ-1:0]         flag,
   output logic [DATA_W-1:0]        rdata,
   output logic [2*N_IRQ-1:0]       sense,
   output logic [N_FIELD*LVL_W-1:0] lvl,
   output logic                     level_mode
);

   localparam int FPR    = DATA_W / SLOT_W;
   localparam int N_PREG = (N_FIELD + FPR - 1) / FPR;
   localparam int A_MODE = ADDR_PRIO0 + N_PREG;

   logic [2*N_IRQ-1:0]       sense_q;
   logic [N_FIELD*LVL_W-1:0] lvl_q;
   logic                     mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         lvl_q   <= '0;
         mode_q  <= 1'b0;
      end else if (we) begin
         if (addr == ADDR_W'(ADDR_SENSE)) sense_q <= wdata[2*N_IRQ-1:0];
         if (addr == ADDR_W'(A_MODE))     mode_q  <= wdata[0];
         for (int f = 0; f < N_FIELD; f++) begin
            if (addr == ADDR_W'(ADDR_PRIO0 + f / FPR))
               lvl_q[f*LVL_W +: LVL_W] <= wdata[(f % FPR)*SLOT_W +: LVL_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADDR_SENSE)) rdata[2*N_IRQ-1:0] = sense_q;
      if (addr == ADDR_W'(ADDR_FLAG))  rdata[N_IRQ-1:0]   = flag;
      if (addr == ADDR_W'(A_MODE))     rdata[0]           = mode_q;
      for (int f = 0; f < N_FIELD; f++) begin
         if (addr == ADDR_W'(ADDR_PRIO0 + f / FPR))
            rdata[(f % FPR)*SLOT_W +: LVL_W] = lvl_q[f*LVL_W +: LVL_W];
      end
   end

   assign sense      = sense_q;
   assign lvl        = lvl_q;
   assign level_mode = mode_q;

endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
   parameter int N_SRC    = 16,
   parameter int N_IRQ    = 8,
   parameter int LVL_W    = 3,
   parameter int VEC_W    = 8,
   parameter int IRQ_VEC0 = 16,
   parameter int INT_VEC0 = 24,
   parameter int NMI_VEC  = 7
) (
   input  logic                   active,
   input  logic                   nmi_pend,
   input  logic                   level_mode,
   input  logic                   cpu_imask,
   input  logic [LVL_W-1:0]       cpu_level,
   input  logic [N_SRC-1:0]       src_req,
   input  logic [N_SRC*LVL_W-1:0] src_lvl,
   output logic                   valid,
   output logic [VEC_W-1:0]       vector
);

   function automatic logic [VEC_W-1:0] vec_of(input int i);
      if (i < N_IRQ) return VEC_W'(IRQ_VEC0 + i);
      else           return VEC_W'(INT_VEC0 + i - N_IRQ);
   endfunction

   logic             found;
   logic [LVL_W-1:0] best_lvl;
   logic [VEC_W-1:0] best_vec;
   logic [LVL_W-1:0] cand_lvl;
   logic             cand_ok;

   // scan in ascending vector order; a later source must strictly beat
   // the held one, so ties stay with the lower vector
   always_comb begin
      found    = 1'b0;
      best_lvl = '0;
      best_vec = '0;
      cand_lvl = '0;
      cand_ok  = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         cand_lvl = level_mode ? src_lvl[i*LVL_W +: LVL_W] : '0;
         cand_ok  = src_req[i] && (level_mode ? (cand_lvl > cpu_level) : !cpu_imask);
         if (cand_ok && (!found || cand_lvl > best_lvl)) begin
            found    = 1'b1;
            best_lvl = cand_lvl;
            best_vec = vec_of(i);
         end
      end
   end

   always_comb begin
      valid  = active && (nmi_pend || found);
      vector = '0;
      if (active) begin
         if (nmi_pend)   vector = VEC_W'(NMI_VEC);
         else if (found) vector = best_vec;
      end
   end

endmodule

// File: rtl/ipc_top.sv
module ipc_top
   import ipc_pkg::*;
#(
   parameter int N_IRQ         = 8,
   parameter int N_INT         = 8,
   parameter int INT_PER_FIELD = 2,
   parameter int LVL_W         = 3,
   parameter int DATA_W        = 16,
   parameter int ADDR_W        = 3,
   parameter int VEC_W         = 8,
   parameter int IRQ_VEC0      = 16,
   parameter int INT_VEC0      = 24,
   parameter int NMI_VEC       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              nmi_pin,
   input  logic [N_IRQ-1:0]  irq_pin,
   input  logic [N_INT-1:0]  int_req,
   input  logic              cpu_imask,
   input  logic [LVL_W-1:0]  cpu_level,
   output logic              int_valid,
   output logic [VEC_W-1:0]  int_vector,
   input  logic              int_ack
);

   localparam int N_SRC   = N_IRQ + N_INT;
   localparam int N_FIELD = N_IRQ + N_INT / INT_PER_FIELD;
   localparam int FPR     = DATA_W / SLOT_W;
   localparam int N_PREG  = (N_FIELD + FPR - 1) / FPR;

   // elaboration-time parameter checks
   if (2 * N_IRQ > DATA_W) begin : g_bad_sense
      $error("sense fields do not fit the data word");
   end
   if (LVL_W > SLOT_W) begin : g_bad_lvl
      $error("level width exceeds the priority slot");
   end
   if (N_INT % INT_PER_FIELD != 0) begin : g_bad_share
      $error("internal sources must divide evenly into shared fields");
   end
   if (ADDRS_NEEDED(N_PREG) > (1 << ADDR_W)) begin : g_bad_addr
      $error("register map does not fit the address width");
   end
   if (INT_VEC0 + N_INT > (1 << VEC_W) || IRQ_VEC0 + N_IRQ > INT_VEC0) begin : g_bad_vec
      $error("vector ranges overlap or overflow");
   end

   function automatic int ADDRS_NEEDED(input int npreg);
      return ADDR_PRIO0 + npreg + 1;
   endfunction

   logic [N_IRQ-1:0]         flag_q;
   logic [2*N_IRQ-1:0]       sense;
   logic [N_FIELD*LVL_W-1:0] fld_lvl;
   logic                     level_mode;
   logic [N_SRC*LVL_W-1:0]   src_lvl;
   logic                     nmi_prev_q;
   logic                     nmi_pend_q;
   logic                     flag_wr;

   assign flag_wr = reg_we && (reg_addr == ADDR_W'(ADDR_FLAG));

   ipc_sense #(.N_IRQ(N_IRQ)) i_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (irq_pin),
      .sense    (sense),
      .clr_we   (flag_wr),
      .clr_keep (reg_wdata[N_IRQ-1:0]),
      .flag     (flag_q)
   );

   ipc_regs #(
      .N_IRQ   (N_IRQ),
      .N_FIELD (N_FIELD),
      .LVL_W   (LVL_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (reg_we),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .flag       (flag_q),
      .rdata      (reg_rdata),
      .sense      (sense),
      .lvl        (fld_lvl),
      .level_mode (level_mode)
   );

   // route each source to its priority field; internal lines share fields
   for (genvar s = 0; s < N_SRC; s++) begin : g_map
      if (s < N_IRQ) begin : g_ext
         assign src_lvl[s*LVL_W +: LVL_W] = fld_lvl[s*LVL_W +: LVL_W];
      end else begin : g_int
         localparam int FLD = N_IRQ + (s - N_IRQ) / INT_PER_FIELD;
         assign src_lvl[s*LVL_W +: LVL_W] = fld_lvl[FLD*LVL_W +: LVL_W];
      end
   end

   // nonmaskable request: armed by a rising pin, retired by acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev_q <= 1'b1;
         nmi_pend_q <= 1'b0;
      end else begin
         nmi_prev_q <= nmi_pin;
         nmi_pend_q <= (nmi_pin & ~nmi_prev_q) | (nmi_pend_q & ~int_ack);
      end
   end

   ipc_arbiter #(
      .N_SRC    (N_SRC),
      .N_IRQ    (N_IRQ),
      .LVL_W    (LVL_W),
      .VEC_W    (VEC_W),
      .IRQ_VEC0 (IRQ_VEC0),
      .INT_VEC0 (INT_VEC0),
      .NMI_VEC  (NMI_VEC)
   ) i_arb (
      .active     (rst_n),
      .nmi_pend   (nmi_pend_q),
      .level_mode (level_mode),
      .cpu_imask  (cpu_imask),
      .cpu_level  (cpu_level),
      .src_req    ({int_req, flag_q}),
      .src_lvl    (src_lvl),
      .valid      (int_valid),
      .vector     (int_vector)
   );

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
   parameter int N_IRQ     = 8,
   parameter int LVL_W     = 3,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 3,
   parameter int VEC_W     = 8,
   parameter int NMI_VEC   = 7,
   parameter int FLAG_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              cpu_imask,
   input logic [LVL_W-1:0]  cpu_level,
   input logic              int_valid,
   input logic [VEC_W-1:0]  int_vector,
   input logic [N_IRQ-1:0]  flag_q,
   input logic              nmi_pend_q,
   input logic              level_mode
);

   // R3: a flag only falls where a flag write carried a 0
   a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flag_q) & ~flag_q &
        ~($past(reg_we && reg_addr == ADDR_W'(FLAG_ADDR)) ? ~$past(reg_wdata[N_IRQ-1:0]) : '0)) == '0));

   // R6: mask bit blocks all maskable sources in mask mode
   a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && cpu_imask && !nmi_pend_q) |-> !int_valid);

   // R7: at the top mask level nothing maskable passes
   a_r7_top_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (level_mode && cpu_level == '1 && !nmi_pend_q) |-> !int_valid);

   // R10: a pending nonmaskable request is always the one presented
   a_r10_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend_q |-> (int_valid && int_vector == VEC_W'(NMI_VEC)));

   // R11: vector is zero whenever nothing is presented
   a_r11_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !int_valid |-> int_vector == '0);

   // R12: reset silences the request output
   a_r12_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |-> !int_valid);

endmodule

bind ipc_top ipc_checker #(
   .N_IRQ     (N_IRQ),
   .LVL_W     (LVL_W),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .VEC_W     (VEC_W),
   .NMI_VEC   (NMI_VEC),
   .FLAG_ADDR (1)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .cpu_imask  (cpu_imask),
   .cpu_level  (cpu_level),
   .int_valid  (int_valid),
   .int_vector (int_vector),
   .flag_q     (flag_q),
   .nmi_pend_q (nmi_pend_q),
   .level_mode (level_mode)
);

// File: tb/test_ipc_top.sv
module test_ipc_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we;
   logic [2:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata;
   logic        nmi_pin;
   logic [7:0]  irq_pin;
   logic [7:0]  int_req;
   logic        cpu_imask;
   logic [2:0]  cpu_level;
   logic        int_valid;
   logic [7:0]  int_vector;
   logic        int_ack;

   always #4 clk = ~clk;   // 125 MHz

   ipc_top i_ipc_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_pin(nmi_pin),
      .irq_pin(irq_pin), .int_req(int_req), .cpu_imask(cpu_imask),
      .cpu_level(cpu_level), .int_valid(int_valid), .int_vector(int_vector),
      .int_ack(int_ack)
   );

   int    errors = 0;
   int    checks = 0;
   bit    done   = 0;
   string tag    = "R12";

   // behavioural reference state
   bit [1:0] m_sense [8];
   bit       m_flag  [8];
   bit       m_prev  [8];
   bit [2:0] m_lvl   [12];
   bit       m_mode;
   bit       m_nmi;
   bit       m_nmi_prev;

   function automatic int lvl_of(int s);
      if (s < 8) return m_lvl[s];
      return m_lvl[8 + (s - 8) / 2];
   endfunction

   function automatic void model_out(output bit v, output int vec);
      int best_score;
      bit any;
      v = 0; vec = 0; any = 0; best_score = 0;
      if (rst_n !== 1'b1) return;
      if (m_nmi) begin v = 1; vec = 7; return; end
      for (int s = 0; s < 16; s++) begin
         bit pend;
         int vn, sc;
         pend = (s < 8) ? m_flag[s] : int_req[s-8];
         vn   = (s < 8) ? 16 + s : 24 + s - 8;
         if (!pend) continue;
         if (m_mode) begin
            if (lvl_of(s) <= int'(cpu_level)) continue;
            sc = lvl_of(s) * 1000 - vn;
         end else begin
            if (cpu_imask) continue;
            sc = -vn;
         end
         if (!any || sc > best_score) begin any = 1; best_score = sc; vec = vn; end
      end
      v = any;
   endfunction

   function automatic int model_rd(int a);
      int r;
      r = 0;
      case (a)
         0: for (int k = 0; k < 8; k++) r |= int'(m_sense[k]) << (2*k);
         1: for (int k = 0; k < 8; k++) r |= int'(m_flag[k]) << k;
         2, 3, 4: for (int j = 0; j < 4; j++) r |= int'(m_lvl[(a-2)*4 + j]) << (4*j);
         5: r = int'(m_mode);
         default: r = 0;
      endcase
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 8; k++) begin m_sense[k] = 0; m_flag[k] = 0; m_prev[k] = 1; end
         for (int f = 0; f < 12; f++) m_lvl[f] = 0;
         m_mode = 0; m_nmi = 0; m_nmi_prev = 1;
      end else begin
         for (int k = 0; k < 8; k++) begin
            bit cur, ev, cl;
            cur = irq_pin[k];
            case (m_sense[k])
               2'd0: ev = !cur;
               2'd1: ev = m_prev[k] && !cur;
               2'd2: ev = !m_prev[k] && cur;
               default: ev = m_prev[k] != cur;
            endcase
            cl = reg_we && reg_addr == 3'd1 && !reg_wdata[k];
            m_flag[k] = ev || (m_flag[k] && !cl);
            m_prev[k] = cur;
         end
         m_nmi = (nmi_pin && !m_nmi_prev) || (m_nmi && !int_ack);
         m_nmi_prev = nmi_pin;
         if (reg_we) begin
            if (reg_addr == 3'd0)
               for (int k = 0; k < 8; k++) m_sense[k] = reg_wdata[2*k +: 2];
            if (reg_addr >= 3'd2 && reg_addr <= 3'd4)
               for (int j = 0; j < 4; j++) m_lvl[(int'(reg_addr)-2)*4 + j] = reg_wdata[4*j +: 3];
            if (reg_addr == 3'd5) m_mode = reg_wdata[0];
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare against the reference away from the active edge
   always @(negedge clk) begin
      bit v; int vec;
      if (!done) begin
         model_out(v, vec);
         chk("int_valid", int'(int_valid), int'(v));
         chk("int_vector", int'(int_vector), vec);
         if (rst_n === 1'b1) chk("reg_rdata", int'(reg_rdata), model_rd(int'(reg_addr)));
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(int a, int d);
      reg_we = 1; reg_addr = 3'(a); reg_wdata = 16'(d);
      tick();
      reg_we = 0; reg_addr = 3'd1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; nmi_pin = 0;
      irq_pin = 8'hFF; int_req = 8'hFF; cpu_imask = 1; cpu_level = 3'd7; int_ack = 0;
      tag = "R12";
      tick(3);
      int_req = 0;
      tick();
      rst_n = 1;
      tag = "R1";
      for (int a = 0; a < 8; a++) begin reg_addr = 3'(a); tick(); end

      // R2: one IRQ per sense encoding
      tag = "R2";
      wr(0, 16'h00E4);
      irq_pin[3:0] = 4'h0; tick(3);
      irq_pin[3:0] = 4'hF; tick(3);

      // R3: write-0 clears, write-1 keeps, held low level re-arms
      tag = "R3";
      irq_pin[0] = 0; tick();
      wr(1, 16'h0000); tick();
      irq_pin[0] = 1; tick();
      irq_pin[1] = 0; tick();
      wr(1, 16'hFFFF); tick();
      wr(1, 16'hFFFD); tick();
      irq_pin[1] = 1; tick();
      wr(1, 16'h0000); tick(2);

      // R4: priority bank, reserved bits read 0
      tag = "R4";
      wr(2, 16'hFFFF); reg_addr = 2; tick();
      wr(3, 16'h1234); reg_addr = 3; tick();
      wr(4, 16'h7654); reg_addr = 4; tick();

      // R5: mode register and unused addresses
      tag = "R5";
      wr(6, 16'hFFFF); reg_addr = 6; tick();
      wr(7, 16'hFFFF); reg_addr = 7; tick();
      wr(5, 16'hFFFF); reg_addr = 5; tick();
      wr(5, 16'h0000); reg_addr = 5; tick();
      wr(2, 16'h0300); wr(3, 16'h0060); wr(4, 16'h7026);

      // R6: mask mode
      tag = "R6";
      cpu_imask = 1;
      irq_pin[5] = 0; tick(); irq_pin[5] = 1;
      irq_pin[2] = 0; tick(); irq_pin[2] = 1; tick(3);
      cpu_imask = 0; tick(2);
      int_req[0] = 1; tick(2);
      wr(1, 16'hFFFB); tick();
      wr(1, 16'h0000); tick(2);
      int_req = 0; tick();

      // R7 / R8: level mode sweeps
      tag = "R7";
      wr(5, 1);
      cpu_imask = 1;
      irq_pin[5] = 0; tick(); irq_pin[5] = 1;
      irq_pin[2] = 0; tick(); irq_pin[2] = 1;
      int_req = 8'h41;
      for (int l = 0; l < 8; l++) begin cpu_level = 3'(l); tick(2); end
      tag = "R8";
      int_req = 8'h03;
      for (int l = 0; l < 8; l++) begin cpu_level = 3'(l); tick(2); end
      tag = "R7";
      wr(1, 0);
      int_req = 8'h04;
      for (int l = 0; l < 8; l++) begin cpu_level = 3'(l); tick(); end
      int_req = 0;

      // R9: walk every vector
      tag = "R9";
      wr(5, 0); cpu_imask = 0;
      for (int m = 0; m < 8; m++) begin int_req = 8'(1 << m); tick(); end
      int_req = 0;
      wr(0, 0);
      for (int k = 0; k < 8; k++) begin
         irq_pin = ~8'(1 << k); tick();
         irq_pin = 8'hFF; tick();
         wr(1, 0);
      end

      // R10: nonmaskable under full masking
      tag = "R10";
      wr(5, 1); cpu_level = 3'd7; cpu_imask = 1;
      nmi_pin = 1; tick(3);
      int_ack = 1; tick();
      int_ack = 0; tick(3);
      nmi_pin = 0; tick();
      nmi_pin = 1; tick(2);
      int_ack = 1; tick();
      int_ack = 0; nmi_pin = 0; tick(2);

      // R11: maskable acknowledge leaves flags alone
      tag = "R11";
      wr(5, 0); cpu_imask = 0;
      wr(0, 16'h0040);
      irq_pin[3] = 0; tick(); irq_pin[3] = 1; tick();
      int_ack = 1; tick();
      int_ack = 0; tick(2);
      wr(1, 0); tick(2);

      // R12: reset in the middle of activity
      tag = "R12";
      int_req = 8'hFF;
      rst_n = 0; tick(3);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule